// File: doc/BRIEF.md
# Banked GPIO Interrupt Router

This block collects the pending interrupt flags of every port in one GPIO bank and steers them onto a small set of interrupt output lines. Each port carries up to eight pins. For every pairing of port and output line there is a routing mask: a set bit connects that pin of the port to that line, so one pin may drive any subset of the lines. The trigger logic that produces the pending flags lives elsewhere; here the flags arrive as plain inputs.

Software programs the masks over a simple single-cycle register bus and reads, for each port and line, a status word holding the pending pins that are routed to that line. Each output line is the registered OR of its status words across all ports. A security register holds two sticky protect bits. Once either bit is set, the routing configuration is frozen until reset. While the read-protect bit is set, the masks are also hidden from reads.

The number of ports, the number of lines and the pin count of each port are parameters. The default build has four ports with 8, 5, 3 and 8 pins, and eight lines.

Top module: `irq_route_top`

## Requirements
- R1: After reset, the line-0 mask of each port has ones in every bit below that port's pin count, and all other masks are zero. Both protect bits read zero and `irq_o` is all zero.
- R2: The routing mask for port p and line x is at byte address 0x14 + p*0x20 + x*4, with bit n routing pin n. A write there stores the data. A read presents the word on `rsp_rdata_o` with `rsp_valid_o` high in the cycle after the request.
- R3: Mask bits at or above a port's pin count always read zero, and pending flags on those pins reach no line.
- R4: The status word for port p and line x is at 0x100 + p*0x20 + x*4. It reads as that port's pending flags ANDed with its line-x mask.
- R5: `irq_o[x]` goes high one clock after any port has a pending pin routed to line x, and is low one clock after none has.
- R6: The security register is at 0x0C. Bit 27 is read-protect and bit 28 is write-protect. Writing a 1 to either bit sets it. Writing a 0 does not clear it; only reset clears it.
- R7: While either protect bit is set, writes to routing masks are ignored.
- R8: While read-protect is set, routing masks read as zero. Status words and routing behaviour are unaffected.
- R9: Addresses that map to no register read as zero, and writes to them change nothing.
- R10: A pin routed to several lines raises each of those lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid_i | input | 1 | Bus request strobe, one cycle per access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (9) | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata_o | output | 32 | Read data |
| pend_i | input | NUM_PORTS*8 (32) | Pending flags, port p on bits [8p+7:8p] |
| irq_o | output | NUM_LINES (8) | One interrupt output per line |

## Verification
The assertions assume that the bus carries at most one access per cycle and that the internal reset has been released before the first access. Under these assumptions a protect bit can never be set in the same cycle as a mask write. The assertions also assume that `pend_i` changes only between clock edges. The bench drives every input at the falling edge and issues one access per task call. It waits several cycles after releasing reset and holds the pending vector steady across each sampled edge, so the registered outputs are compared only against settled inputs.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int WORD_W      = 32;
  localparam int MAX_PINS    = 8;
  localparam int SEC_OFFS    = 'h0C;
  localparam int MASK_BASE   = 'h14;
  localparam int STAT_BASE   = 'h100;
  localparam int PORT_STRIDE = 'h20;
  localparam int RPROT_BIT   = 27;
  localparam int WPROT_BIT   = 28;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_SEC  = 2'd1,
    REG_MASK = 2'd2,
    REG_STAT = 2'd3
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [2:0] port;
    logic [2:0] line;
  } reg_sel_t;

  // Map a byte address onto a register kind and its port/line indices.
  function automatic reg_sel_t decode_addr(input int unsigned addr,
                                           input int unsigned nports,
                                           input int unsigned nlines);
    reg_sel_t    s;
    int unsigned rel;
    s.kind = REG_NONE;
    s.port = 3'd0;
    s.line = 3'd0;
    if (addr == SEC_OFFS) begin
      s.kind = REG_SEC;
    end else if (addr >= MASK_BASE && addr < MASK_BASE + nports * PORT_STRIDE) begin
      rel = addr - MASK_BASE;
      if ((rel % 4) == 0 && (rel % PORT_STRIDE) < nlines * 4) begin
        s.kind = REG_MASK;
        s.port = 3'(rel / PORT_STRIDE);
        s.line = 3'((rel % PORT_STRIDE) / 4);
      end
    end else if (addr >= STAT_BASE && addr < STAT_BASE + nports * PORT_STRIDE) begin
      rel = addr - STAT_BASE;
      if ((rel % 4) == 0 && (rel % PORT_STRIDE) < nlines * 4) begin
        s.kind = REG_STAT;
        s.port = 3'(rel / PORT_STRIDE);
        s.line = 3'((rel % PORT_STRIDE) / 4);
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/irq_route_rst_sync.sv
module irq_route_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/irq_route_sec.sv
module irq_route_sec (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic        rprot_o,
  output logic        wprot_o
);
  import irq_route_pkg::*;

  logic rprot_q, wprot_q, rprot_d, wprot_d, ld;

  // Protect bits only accumulate: a written 0 leaves a set bit in place.
  always_comb begin
    ld      = wr_en_i;
    rprot_d = rprot_q | wr_data_i[RPROT_BIT];
    wprot_d = wprot_q | wr_data_i[WPROT_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rprot_q <= 1'b0;
      wprot_q <= 1'b0;
    end else if (ld) begin
      rprot_q <= rprot_d;
      wprot_q <= wprot_d;
    end
  end

  assign rprot_o = rprot_q;
  assign wprot_o = wprot_q;
endmodule

// File: rtl/irq_route_masks.sv
module irq_route_masks #(
  parameter int                     NUM_PORTS = 4,
  parameter int                     NUM_LINES = 8,
  parameter logic [NUM_PORTS*4-1:0] PORT_PINS = 16'h8358
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   wr_en_i,
  input  logic [2:0]                             wr_port_i,
  input  logic [2:0]                             wr_line_i,
  input  logic [7:0]                             wr_data_i,
  output logic [NUM_PORTS-1:0][NUM_LINES-1:0][7:0] mask_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int         PINS      = int'(PORT_PINS[4*p +: 4]);
    localparam logic [7:0] PIN_VALID = 8'((1 << PINS) - 1);

    for (genvar x = 0; x < NUM_LINES; x++) begin : g_line
      localparam logic [7:0] RST_VAL = (x == 0) ? PIN_VALID : 8'h00;

      logic [7:0] mask_q, mask_d;
      logic       ld;

      always_comb begin
        ld     = wr_en_i && (wr_port_i == 3'(p)) && (wr_line_i == 3'(x));
        mask_d = wr_data_i & PIN_VALID;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  mask_q <= RST_VAL;
        else if (ld)  mask_q <= mask_d;
      end

      assign mask_o[p][x] = mask_q;
    end
  end
endmodule

// File: rtl/irq_route_merge.sv
module irq_route_merge #(
  parameter int NUM_PORTS = 4,
  parameter int NUM_LINES = 8
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [NUM_PORTS*8-1:0]                 pend_i,
  input  logic [NUM_PORTS-1:0][NUM_LINES-1:0][7:0] mask_i,
  output logic [NUM_PORTS-1:0][NUM_LINES-1:0][7:0] status_o,
  output logic [NUM_LINES-1:0]                   irq_o
);
  logic [NUM_LINES-1:0] irq_d, irq_q;

  always_comb begin
    irq_d = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int x = 0; x < NUM_LINES; x++) begin
        status_o[p][x] = pend_i[8*p +: 8] & mask_i[p][x];
        irq_d[x]       = irq_d[x] | (|status_o[p][x]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top #(
  parameter int                     NUM_PORTS = 4,
  parameter int                     NUM_LINES = 8,
  parameter logic [NUM_PORTS*4-1:0] PORT_PINS = 16'h8358,
  parameter int                     ADDR_W    = 9
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic                   req_write_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic [31:0]            req_wdata_i,
  output logic                   rsp_valid_o,
  output logic [31:0]            rsp_rdata_o,
  input  logic [NUM_PORTS*8-1:0] pend_i,
  output logic [NUM_LINES-1:0]   irq_o
);
  import irq_route_pkg::*;

  logic                                     rst_sync_n;
  reg_sel_t                                 sel;
  logic                                     sec_wr, mask_wr, rd_req;
  logic                                     rprot, wprot;
  logic [NUM_PORTS-1:0][NUM_LINES-1:0][7:0] mask;
  logic [NUM_PORTS-1:0][NUM_LINES-1:0][7:0] status;
  logic [31:0]                              rd_d, rdata_q;
  logic                                     rvalid_q;

  irq_route_rst_sync u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  always_comb begin
    sel     = decode_addr(int'(req_addr_i), NUM_PORTS, NUM_LINES);
    rd_req  = req_valid_i && !req_write_i;
    sec_wr  = req_valid_i && req_write_i && (sel.kind == REG_SEC);
    // Routing is configurable only while neither protect bit is set.
    mask_wr = req_valid_i && req_write_i && (sel.kind == REG_MASK) && !rprot && !wprot;
  end

  irq_route_sec u_sec (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .wr_en_i  (sec_wr),
    .wr_data_i(req_wdata_i),
    .rprot_o  (rprot),
    .wprot_o  (wprot)
  );

  irq_route_masks #(
    .NUM_PORTS(NUM_PORTS),
    .NUM_LINES(NUM_LINES),
    .PORT_PINS(PORT_PINS)
  ) u_masks (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .wr_en_i  (mask_wr),
    .wr_port_i(sel.port),
    .wr_line_i(sel.line),
    .wr_data_i(req_wdata_i[7:0]),
    .mask_o   (mask)
  );

  irq_route_merge #(
    .NUM_PORTS(NUM_PORTS),
    .NUM_LINES(NUM_LINES)
  ) u_merge (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .pend_i  (pend_i),
    .mask_i  (mask),
    .status_o(status),
    .irq_o   (irq_o)
  );

  // Read-data selection.
  always_comb begin
    rd_d = '0;
    case (sel.kind)
      REG_SEC: begin
        rd_d[RPROT_BIT] = rprot;
        rd_d[WPROT_BIT] = wprot;
      end
      REG_MASK: begin
        for (int p = 0; p < NUM_PORTS; p++)
          for (int x = 0; x < NUM_LINES; x++)
            if (!rprot && sel.port == 3'(p) && sel.line == 3'(x))
              rd_d[7:0] = mask[p][x];
      end
      REG_STAT: begin
        for (int p = 0; p < NUM_PORTS; p++)
          for (int x = 0; x < NUM_LINES; x++)
            if (sel.port == 3'(p) && sel.line == 3'(x))
              rd_d[7:0] = status[p][x];
      end
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) rvalid_q <= 1'b0;
    else             rvalid_q <= rd_req;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (rd_req)  rdata_q <= rd_d;
  end

  assign rsp_valid_o = rvalid_q;
  assign rsp_rdata_o = rdata_q;
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int                     NUM_PORTS = 4,
  parameter int                     NUM_LINES = 8,
  parameter logic [NUM_PORTS*4-1:0] PORT_PINS = 16'h8358,
  parameter int                     ADDR_W    = 9
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     req_valid_i,
  input  logic                                     req_write_i,
  input  logic [ADDR_W-1:0]                        req_addr_i,
  input  logic                                     rsp_valid_o,
  input  logic [31:0]                              rsp_rdata_o,
  input  logic [NUM_PORTS*8-1:0]                   pend_i,
  input  logic [NUM_LINES-1:0]                     irq_o,
  input  logic                                     rprot,
  input  logic                                     wprot,
  input  logic [NUM_PORTS-1:0][NUM_LINES-1:0][7:0] mask
);
  import irq_route_pkg::*;

  reg_sel_t             sel;
  logic [NUM_LINES-1:0] line_hit;

  always_comb begin
    sel      = decode_addr(int'(req_addr_i), NUM_PORTS, NUM_LINES);
    line_hit = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      for (int x = 0; x < NUM_LINES; x++)
        if ((pend_i[8*p +: 8] & mask[p][x]) != 8'h00) line_hit[x] = 1'b1;
  end

  assert_rd_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);

  assert_irq_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(line_hit)));

  assert_rprot_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rprot |=> rprot);

  assert_wprot_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wprot |=> wprot);

  assert_frozen_masks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rprot || wprot) |=> $stable(mask));

  assert_hidden_masks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && sel.kind == REG_MASK && rprot) |=> (rsp_rdata_o == 32'h0));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pin_chk
    localparam int         PINS      = int'(PORT_PINS[4*p +: 4]);
    localparam logic [7:0] PIN_VALID = 8'((1 << PINS) - 1);
    for (genvar x = 0; x < NUM_LINES; x++) begin : g_line_chk
      assert_unused_pins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask[p][x] & ~PIN_VALID) == 8'h00);
    end
  end
endmodule

bind irq_route_top irq_route_chk #(
  .NUM_PORTS(NUM_PORTS),
  .NUM_LINES(NUM_LINES),
  .PORT_PINS(PORT_PINS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_sync_n),
  .req_valid_i(req_valid_i),
  .req_write_i(req_write_i),
  .req_addr_i (req_addr_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_rdata_o(rsp_rdata_o),
  .pend_i     (pend_i),
  .irq_o      (irq_o),
  .rprot      (rprot),
  .wprot      (wprot),
  .mask       (mask)
);

// File: tb/sim_irq_route_top.sv
module sim_irq_route_top;
  localparam int NUM_PORTS = 4;
  localparam int NUM_LINES = 8;
  localparam int ADDR_W    = 9;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic                   req_valid, req_write;
  logic [ADDR_W-1:0]      req_addr;
  logic [31:0]            req_wdata;
  logic                   rsp_valid;
  logic [31:0]            rsp_rdata;
  logic [NUM_PORTS*8-1:0] pend;
  logic [NUM_LINES-1:0]   irq;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done     = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  irq_route_top #(
    .NUM_PORTS(NUM_PORTS),
    .NUM_LINES(NUM_LINES),
    .PORT_PINS(16'h8358),
    .ADDR_W   (ADDR_W)
  ) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_valid_i(req_valid),
    .req_write_i(req_write),
    .req_addr_i (req_addr),
    .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata),
    .pend_i     (pend),
    .irq_o      (irq)
  );

  function automatic int mask_a(int p, int x);
    return 'h14 + p * 'h20 + x * 4;
  endfunction

  function automatic int stat_a(int p, int x);
    return 'h100 + p * 'h20 + x * 4;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = ADDR_W'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(a);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pend_irq(input logic [31:0] v, input logic [7:0] exp, input string tag);
    @(negedge clk);
    pend = v;
    @(negedge clk);
    check(tag, {24'h0, irq}, {24'h0, exp});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pend = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Monitor: compare each read response with the oldest expected item.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("unexpected read response", rsp_rdata, 32'hx);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string       t = tag_q.pop_front();
        check(t, rsp_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    pend = '0; rst_n = 1'b0;
    do_reset();

    // Reset state
    check("R1 irq after reset", {24'h0, irq}, 32'h0);
    bus_rd(mask_a(0, 0), 32'h0000_00FF, "R1 port0 line0 default");
    bus_rd(mask_a(1, 0), 32'h0000_001F, "R1 port1 line0 default");
    bus_rd(mask_a(2, 0), 32'h0000_0007, "R1 port2 line0 default");
    bus_rd(mask_a(3, 0), 32'h0000_00FF, "R1 port3 line0 default");
    bus_rd(mask_a(0, 3), 32'h0000_0000, "R1 port0 line3 default");
    bus_rd('h0C,         32'h0000_0000, "R1 security default");

    // Mask programming and pin-count clipping
    bus_wr(mask_a(0, 5), 32'h0000_00A5);
    bus_rd(mask_a(0, 5), 32'h0000_00A5, "R2 port0 line5 readback");
    bus_wr(mask_a(1, 2), 32'hFFFF_FFFF);
    bus_rd(mask_a(1, 2), 32'h0000_001F, "R3 port1 line2 clipped to 5 pins");

    // Routing and status
    pend_irq(32'h0000_0081, 8'h21, "R10 pin routed to lines 0 and 5");
    bus_rd(stat_a(0, 5), 32'h0000_0081, "R4 status port0 line5");
    bus_rd(stat_a(0, 0), 32'h0000_0081, "R4 status port0 line0");
    pend_irq(32'h0000_0400, 8'h05, "R5 port1 pin2 to lines 0 and 2");
    pend_irq(32'h00F8_0000, 8'h00, "R3 pending above port2 pin count");
    bus_rd(stat_a(2, 0), 32'h0000_0000, "R3 status of unused port2 pins");
    pend_irq(32'h0000_0000, 8'h00, "R5 lines drop when nothing pending");

    // Unmapped addresses
    bus_wr('h008, 32'hFFFF_FFFF);
    bus_rd('h008, 32'h0000_0000, "R9 unmapped read");
    bus_rd('h0F0, 32'h0000_0000, "R9 gap before status read");
    bus_rd(mask_a(0, 0), 32'h0000_00FF, "R9 mask untouched by unmapped write");

    // Write protect
    bus_wr('h0C, 32'h1000_0000);
    bus_rd('h0C, 32'h1000_0000, "R6 write-protect set");
    bus_wr(mask_a(0, 5), 32'h0000_0000);
    bus_rd(mask_a(0, 5), 32'h0000_00A5, "R7 mask write ignored under write-protect");
    pend_irq(32'h0000_0001, 8'h21, "R7 routing unchanged under write-protect");
    bus_wr('h0C, 32'h0000_0000);
    bus_rd('h0C, 32'h1000_0000, "R6 zero write does not clear");
    bus_wr('h0C, 32'h0800_0000);
    bus_rd('h0C, 32'h1800_0000, "R6 read-protect added");
    bus_rd(mask_a(0, 5), 32'h0000_0000, "R8 mask hidden under read-protect");
    bus_rd(stat_a(0, 5), 32'h0000_0001, "R8 status readable under read-protect");

    // Read-protect alone freezes routing
    do_reset();
    bus_rd('h0C, 32'h0000_0000, "R1 security cleared by reset");
    bus_wr('h0C, 32'h0800_0000);
    bus_wr(mask_a(3, 1), 32'h0000_00FF);
    pend_irq(32'h0100_0000, 8'h01, "R7 mask write ignored under read-protect");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R2 missing read responses", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule